// File: doc/BRIEF.md
# Scan Channel-Gain Queue Sequencer

This block holds a list of channel and gain entries for a multiplexed analog front end and works through it one entry per conversion. The host first loads the list through a shared byte bus: one strobe latches the byte as the entry index, and another writes the byte as the entry at the latched index. A separate register sets how many entries the list holds.

While an acquisition runs, each conversion strobe presents the entry under the sequencing pointer on registered outputs. The outputs carry the multiplexer channel, the gain code and a unipolar flag for the data formatter. The pointer then moves to the next entry and returns to index 0 after the last one. A start strobe sends the pointer back to the head of the list.

A rule checker watches the entries that lie inside the programmed length. It raises a list error when a multi-entry list has an odd length, or when any entry's channel parity differs from the parity of its index. A second flag reports any range code outside the nine defined codes.

Top module: `cgq_sequencer`

## Requirements
- R1: An entry strobe stores the bus byte at the index last latched by the index strobe. When that entry is presented, the channel output is byte bits [2:0] and the gain output is byte bits [7:4]. Bit 3 has no effect on either output.
- R2: A conversion strobe without start sets valid high in the next cycle and presents the entry the pointer held at the strobe. Valid is high for that one cycle only, and channel and gain hold their values until the next conversion.
- R3: After each conversion the pointer advances by one, and it returns to 0 when the incremented value reaches the list length. A length write of 0 means one entry, so every conversion uses entry 0. A length write above the depth (256) means the full depth.
- R4: A start strobe returns the pointer to 0. When start and a conversion strobe arrive in the same cycle, start wins and no entry is presented (valid stays low).
- R5: When the list length is 2 or more and is odd, the list error flag is high.
- R6: When the list length is 2 or more, the list error flag is high if any entry at index i below the length has channel bit 0 different from bit 0 of i. Entries at or beyond the length do not affect the flag, and a one-entry list never raises it.
- R7: The unipolar flag is high exactly when the presented range code is 4 to 7. It is low for codes 0 to 3 and 8, and for any code above 8.
- R8: The range error flag is high while any entry inside the list has a range code of 9 to 15. Such an entry is still stored and presented unchanged.
- R9: After reset the pointer is 0, the length is 1, all entries are 0, and valid, channel, gain, unipolar and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_we | input | 1 | Latch wr_byte as the entry index |
| entry_we | input | 1 | Write wr_byte as the entry at the latched index |
| wr_byte | input | 8 | Shared host data byte |
| len_we | input | 1 | Load the list length register |
| len_val | input | 9 | List length (0 means 1, above 256 means 256) |
| start | input | 1 | Acquisition start; pointer to 0 |
| conv | input | 1 | Conversion strobe |
| chan_o | output | 3 | Channel of the presented entry |
| gain_o | output | 4 | Range code of the presented entry |
| unipolar_o | output | 1 | Presented range code is unipolar |
| valid_o | output | 1 | One-cycle pulse: a new entry is presented |
| cur_idx_o | output | 8 | Sequencing pointer |
| list_bad_o | output | 1 | List breaks the length or parity rule |
| range_bad_o | output | 1 | An entry in the list has an undefined range code |

## Verification
The checker's properties assume that the length register changes only through len_we and that start and conv are single-cycle strobes sampled on the clock. A shadow copy of the length, kept in the checker, predicts each pointer step. The stimulus drives every strobe for exactly one cycle and changes inputs half a period away from the sampling edge. It also rewrites entries only between conversion bursts, so every presented entry is settled before the bench reads it.

// File: rtl/cgq_pkg.sv
package cgq_pkg;

    localparam int BYTE_W = 8;
    localparam int CHAN_W = 3;
    localparam int CODE_W = 4;
    localparam int CODE_COUNT = 9;

    // stored form of one list entry; bit 3 of the host byte is not kept
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [CHAN_W-1:0] chan;
    } cgq_entry_t;

    function automatic cgq_entry_t unpack_byte(input logic [BYTE_W-1:0] b);
        cgq_entry_t e;
        e.code = b[7:4];
        e.chan = b[2:0];
        return e;
    endfunction

    function automatic logic code_unipolar(input logic [CODE_W-1:0] c);
        return (c >= CODE_W'(4)) && (c <= CODE_W'(7));
    endfunction

    function automatic logic code_undefined(input logic [CODE_W-1:0] c);
        return c >= CODE_W'(CODE_COUNT);
    endfunction

endpackage

// File: rtl/cgq_store.sv
module cgq_store
    import cgq_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              idx_we,
    input  logic              entry_we,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic [IDX_W-1:0]  rd_idx,
    output cgq_entry_t        rd_ent,
    output cgq_entry_t        ents [DEPTH]
);

    logic [IDX_W-1:0] wr_idx;
    cgq_entry_t       mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx <= '0;
        end else if (idx_we) begin
            wr_idx <= wr_byte[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (entry_we) begin
            mem[wr_idx] <= unpack_byte(wr_byte);
        end
    end

    assign rd_ent = mem[rd_idx];
    assign ents   = mem;

endmodule

// File: rtl/cgq_rules.sv
module cgq_rules
    import cgq_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int LEN_W = 9
) (
    input  cgq_entry_t       ents [DEPTH],
    input  logic [LEN_W-1:0] len_eff,
    output logic             list_bad,
    output logic             range_bad
);

    logic [DEPTH-1:0] parity_miss;
    logic [DEPTH-1:0] code_miss;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic in_list;
        assign in_list        = LEN_W'(i) < len_eff;
        assign parity_miss[i] = in_list && (ents[i].chan[0] != 1'(i % 2));
        assign code_miss[i]   = in_list && code_undefined(ents[i].code);
    end

    always_comb begin
        list_bad  = (len_eff > LEN_W'(1)) && (len_eff[0] || (|parity_miss));
        range_bad = |code_miss;
    end

endmodule

// File: rtl/cgq_seq.sv
module cgq_seq
    import cgq_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int LEN_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             conv,
    input  logic [LEN_W-1:0] len_eff,
    input  cgq_entry_t       rd_ent,
    output logic [IDX_W-1:0] ptr,
    output cgq_entry_t       ent_q,
    output logic             uni_q,
    output logic             valid_q
);

    logic [LEN_W-1:0] ptr_inc;

    assign ptr_inc = LEN_W'(ptr) + LEN_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr     <= '0;
            ent_q   <= '0;
            uni_q   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (start) begin
                ptr <= '0;
            end else if (conv) begin
                ent_q   <= rd_ent;
                uni_q   <= code_unipolar(rd_ent.code);
                valid_q <= 1'b1;
                ptr     <= (ptr_inc >= len_eff) ? '0 : ptr_inc[IDX_W-1:0];
            end
        end
    end

endmodule

// File: rtl/cgq_sequencer.sv
module cgq_sequencer
    import cgq_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int LEN_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              idx_we,
    input  logic              entry_we,
    input  logic [7:0]        wr_byte,
    input  logic              len_we,
    input  logic [LEN_W-1:0]  len_val,
    input  logic              start,
    input  logic              conv,
    output logic [2:0]        chan_o,
    output logic [3:0]        gain_o,
    output logic              unipolar_o,
    output logic              valid_o,
    output logic [IDX_W-1:0]  cur_idx_o,
    output logic              list_bad_o,
    output logic              range_bad_o
);

    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(DEPTH);

    logic [LEN_W-1:0] len_q;
    logic [IDX_W-1:0] ptr;
    cgq_entry_t       rd_ent;
    cgq_entry_t       ent_q;
    cgq_entry_t       ents [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= LEN_W'(1);
        end else if (len_we) begin
            if (len_val == '0) begin
                len_q <= LEN_W'(1);
            end else if (len_val > LEN_MAX) begin
                len_q <= LEN_MAX;
            end else begin
                len_q <= len_val;
            end
        end
    end

    cgq_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .idx_we   (idx_we),
        .entry_we (entry_we),
        .wr_byte  (wr_byte),
        .rd_idx   (ptr),
        .rd_ent   (rd_ent),
        .ents     (ents)
    );

    cgq_rules #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_rules (
        .ents      (ents),
        .len_eff   (len_q),
        .list_bad  (list_bad_o),
        .range_bad (range_bad_o)
    );

    cgq_seq #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .conv    (conv),
        .len_eff (len_q),
        .rd_ent  (rd_ent),
        .ptr     (ptr),
        .ent_q   (ent_q),
        .uni_q   (unipolar_o),
        .valid_q (valid_o)
    );

    assign chan_o    = ent_q.chan;
    assign gain_o    = ent_q.code;
    assign cur_idx_o = ptr;

endmodule

// File: rtl/cgq_sequencer_chk.sv
module cgq_sequencer_chk #(
    parameter int DEPTH = 256,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int LEN_W = IDX_W + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             len_we,
    input logic [LEN_W-1:0] len_val,
    input logic             start,
    input logic             conv,
    input logic [2:0]       chan_o,
    input logic [3:0]       gain_o,
    input logic             unipolar_o,
    input logic             valid_o,
    input logic [IDX_W-1:0] cur_idx_o,
    input logic             list_bad_o
);

    // independent model of the effective list length
    logic [LEN_W-1:0] shadow_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_len <= LEN_W'(1);
        end else if (len_we) begin
            shadow_len <= (len_val == '0) ? LEN_W'(1) :
                          (len_val > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : len_val;
        end
    end

    // R2
    a_r2_valid_after_conv: assert property (@(posedge clk) disable iff (rst)
        (conv && !start) |=> valid_o);

    // R2
    a_r2_outputs_hold: assert property (@(posedge clk) disable iff (rst)
        (!conv || start) |=> ($stable(chan_o) && $stable(gain_o) && !valid_o));

    // R3
    a_r3_pointer_step: assert property (@(posedge clk) disable iff (rst)
        (conv && !start) |=> (cur_idx_o ==
            ((LEN_W'($past(cur_idx_o)) + LEN_W'(1) >= $past(shadow_len)) ?
              IDX_W'(0) : IDX_W'($past(cur_idx_o) + IDX_W'(1)))));

    // R4
    a_r4_start_home: assert property (@(posedge clk) disable iff (rst)
        start |=> (cur_idx_o == '0 && !valid_o));

    // R6
    a_r6_single_entry_ok: assert property (@(posedge clk) disable iff (rst)
        (shadow_len == LEN_W'(1)) |-> !list_bad_o);

    // R7
    a_r7_unipolar_match: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (unipolar_o == (gain_o >= 4'd4 && gain_o <= 4'd7)));

endmodule

bind cgq_sequencer cgq_sequencer_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .len_we     (len_we),
    .len_val    (len_val),
    .start      (start),
    .conv       (conv),
    .chan_o     (chan_o),
    .gain_o     (gain_o),
    .unipolar_o (unipolar_o),
    .valid_o    (valid_o),
    .cur_idx_o  (cur_idx_o),
    .list_bad_o (list_bad_o)
);

// File: tb/cgq_sequencer_bench.sv
module cgq_sequencer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       idx_we = 1'b0;
    logic       entry_we = 1'b0;
    logic [7:0] wr_byte = '0;
    logic       len_we = 1'b0;
    logic [8:0] len_val = '0;
    logic       start = 1'b0;
    logic       conv = 1'b0;
    logic [2:0] chan_o;
    logic [3:0] gain_o;
    logic       unipolar_o;
    logic       valid_o;
    logic [7:0] cur_idx_o;
    logic       list_bad_o;
    logic       range_bad_o;

    int checks = 0;
    int errors = 0;

    cgq_sequencer u_cgq_sequencer (
        .clk (clk), .rst (rst), .idx_we (idx_we), .entry_we (entry_we),
        .wr_byte (wr_byte), .len_we (len_we), .len_val (len_val),
        .start (start), .conv (conv), .chan_o (chan_o), .gain_o (gain_o),
        .unipolar_o (unipolar_o), .valid_o (valid_o), .cur_idx_o (cur_idx_o),
        .list_bad_o (list_bad_o), .range_bad_o (range_bad_o)
    );

    always #10 clk = ~clk;

    // {entry byte, expected channel, expected code, expected unipolar}
    localparam logic [15:0] VEC [4] = '{
        {8'h02, 3'd2, 4'd0, 1'b0},
        {8'h55, 3'd5, 4'd5, 1'b1},
        {8'h84, 3'd4, 4'd8, 1'b0},
        {8'h39, 3'd1, 4'd3, 1'b0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic put_idx(input logic [7:0] b);
        wr_byte = b; idx_we = 1'b1;
        @(negedge clk); idx_we = 1'b0;
    endtask

    task automatic put_entry(input logic [7:0] i, input logic [7:0] b);
        put_idx(i);
        wr_byte = b; entry_we = 1'b1;
        @(negedge clk); entry_we = 1'b0;
    endtask

    task automatic put_len(input logic [8:0] n);
        len_val = n; len_we = 1'b1;
        @(negedge clk); len_we = 1'b0;
    endtask

    task automatic do_start();
        start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic do_conv();
        conv = 1'b1;
        @(negedge clk); conv = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 idx", cur_idx_o, 0);
        chk("R9 valid", valid_o, 0);
        chk("R9 chan", chan_o, 0);
        chk("R9 gain", gain_o, 0);
        chk("R9 list_bad", list_bad_o, 0);
        chk("R9 range_bad", range_bad_o, 0);

        for (int k = 0; k < 4; k++) put_entry(8'(k), VEC[k][15:8]);
        put_len(9'd4);
        chk("R6 legal list", list_bad_o, 0);
        chk("R8 defined codes", range_bad_o, 0);

        do_start();
        for (int k = 0; k < 8; k++) begin
            do_conv();
            chk("R1 chan", chan_o, VEC[k % 4][7:5]);
            chk("R1 gain", gain_o, VEC[k % 4][4:1]);
            chk("R7 unipolar", unipolar_o, VEC[k % 4][0]);
            chk("R2 valid", valid_o, 1);
            chk("R3 wrap idx", cur_idx_o, (k + 1) % 4);
        end
        @(negedge clk);
        chk("R2 valid pulse", valid_o, 0);
        chk("R2 hold chan", chan_o, 1);

        do_conv(); do_conv();
        chk("R3 idx mid", cur_idx_o, 2);
        do_start();
        chk("R4 start home", cur_idx_o, 0);
        do_conv(); do_conv();
        start = 1'b1; conv = 1'b1;
        @(negedge clk); start = 1'b0; conv = 1'b0;
        chk("R4 start wins valid", valid_o, 0);
        chk("R4 start wins idx", cur_idx_o, 0);
        do_conv();
        chk("R4 first entry", chan_o, 2);

        put_len(9'd0);
        chk("R6 single ok", list_bad_o, 0);
        do_start();
        for (int k = 0; k < 3; k++) begin
            do_conv();
            chk("R3 len0 chan", chan_o, 2);
            chk("R3 len0 idx", cur_idx_o, 0);
        end

        put_len(9'd3);
        chk("R5 odd length", list_bad_o, 1);
        put_len(9'd4);
        chk("R5 even length", list_bad_o, 0);

        put_entry(8'd1, 8'h54);
        chk("R6 parity miss", list_bad_o, 1);
        put_entry(8'd1, 8'h55);
        chk("R6 parity fixed", list_bad_o, 0);
        put_len(9'd6);
        chk("R6 slot5 in list", list_bad_o, 1);
        put_len(9'd4);
        chk("R6 slot5 outside", list_bad_o, 0);

        put_entry(8'd2, 8'hA4);
        chk("R8 undefined code", range_bad_o, 1);
        do_start();
        do_conv(); do_conv(); do_conv();
        chk("R8 still presented", gain_o, 10);
        chk("R8 chan kept", chan_o, 4);
        chk("R7 code10 not unipolar", unipolar_o, 0);
        put_len(9'd2);
        chk("R8 outside list", range_bad_o, 0);

        put_len(9'd300);
        do_start();
        for (int k = 0; k < 255; k++) do_conv();
        chk("R3 clamp idx255", cur_idx_o, 255);
        do_conv();
        chk("R3 clamp wrap", cur_idx_o, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule